// File: doc/BRIEF.md
# Nine-Bit ROM Bank Controller

This block sits between an 8-bit CPU bus and a cartridge's ROM and RAM arrays. It translates the CPU's 16-bit address into physical array addresses. The CPU sees two ROM windows. The window at 0x0000–0x3FFF always shows ROM bank 0. The window at 0x4000–0x7FFF shows a selectable bank out of as many as 512 banks of 16 KiB. A third window, at 0xA000–0xBFFF, shows one of as many as 16 external RAM banks of 8 KiB.

The CPU selects banks by writing to the ROM address space. The 9-bit ROM bank number has two write ports: one for its low eight bits and one for its top bit. Any bank number may be selected, and that includes bank 0. No number is remapped. The arrays hold a number of banks that is supplied on configuration inputs. A bank number beyond that count reads as zero, and a RAM write to such a bank is blocked. The read path muxes the two array data buses onto the CPU read bus.

Top module: `rom9_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM writes are disabled. A read at 0x4000 therefore addresses physical ROM 0x4000.
- R2: A write to 0x0000–0x1FFF with data 0x0A turns RAM writes on. A write there with any other value turns them off.
- R3: A write to 0x2000–0x2FFF loads the whole data byte into ROM bank bits 7:0 and leaves bit 8 as it was.
- R4: A write to 0x3000–0x3FFF loads data bit 0 into ROM bank bit 8 and leaves bits 7:0 as they were.
- R5: A write to 0x4000–0x5FFF loads data bits 3:0 into the RAM bank.
- R6: Bank 0 written as the ROM bank is used as bank 0 in the switchable window. It is not changed to 1.
- R7: Reads in 0x0000–0x3FFF address physical ROM equal to addr[13:0], whatever the bank register holds.
- R8: Reads in 0x4000–0x7FFF address physical ROM equal to bank*2^14 + addr[13:0].
- R9: The RAM address equals ram_bank*2^13 + addr[12:0].
- R10: rom_oor is high when the ROM bank is at or above rom_banks_cfg. In that state a read from the switchable window returns 0x00.
- R11: ram_oor is high when the RAM bank is at or above ram_banks_cfg, and a count of 0 means no RAM is fitted. In that state a RAM window read returns 0x00 and ram_we stays low.
- R12: ram_we is high only during a bus write to 0xA000–0xBFFF while RAM writes are enabled and ram_oor is low.
- R13: Writes to 0x6000–0x7FFF and to 0x8000–0xFFFF leave every bank register and the enable unchanged.
- R14: A register write takes effect at the clock edge that ends the write cycle. Outputs during that cycle still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| rom_banks_cfg | input | 10 | Number of ROM banks fitted (1–512) |
| ram_banks_cfg | input | 5 | Number of RAM banks fitted (0–16) |
| rom_q | input | 8 | ROM array read data |
| ram_q | input | 8 | RAM array read data |
| rom_addr | output | 23 | Physical ROM byte address |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_we | output | 1 | RAM array write enable |
| rom_oor | output | 1 | ROM bank beyond fitted count |
| ram_oor | output | 1 | RAM bank beyond fitted count |

## Verification
In one cycle the block can both update a bank register and use that register to translate addresses and judge range. The range flags follow the register state and not the address, so they can be watched during the write cycle itself. The bench sets ROM bank 63 against a count of 64 and then writes 0x40 to the low-byte port. It checks that rom_oor is still low before the edge and high after it. The same overlap of the enable register with a RAM-window write is checked by writing to the RAM window straight after a disable write.

// File: rtl/rom9_bank_pkg.sv
package rom9_bank_pkg;

  typedef enum logic [2:0] {
    RG_RAM_KEY,
    RG_ROM_LO,
    RG_ROM_HI,
    RG_RAM_BANK,
    RG_NONE
  } reg_port_e;

  typedef enum logic [1:0] {
    WIN_FIXED,
    WIN_SWITCH,
    WIN_RAM,
    WIN_OTHER
  } window_e;

  localparam logic [7:0] RAM_KEY = 8'h0A;

  function automatic reg_port_e decode_port(input logic [3:0] top);
    if (top[3:1] == 3'b000)      decode_port = RG_RAM_KEY;
    else if (top == 4'h2)        decode_port = RG_ROM_LO;
    else if (top == 4'h3)        decode_port = RG_ROM_HI;
    else if (top[3:1] == 3'b010) decode_port = RG_RAM_BANK;
    else                         decode_port = RG_NONE;
  endfunction

  function automatic window_e decode_window(input logic [3:0] top);
    if (top[3:2] == 2'b00)       decode_window = WIN_FIXED;
    else if (top[3:2] == 2'b01)  decode_window = WIN_SWITCH;
    else if (top[3:1] == 3'b101) decode_window = WIN_RAM;
    else                         decode_window = WIN_OTHER;
  endfunction

  function automatic logic in_range(input logic [9:0] bank, input logic [9:0] count);
    in_range = bank < count;
  endfunction

endpackage

// File: rtl/rom9_bank_regs.sv
module rom9_bank_regs
  import rom9_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  reg_port_e             port,
  input  logic [7:0]            wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  localparam int LO_W = (ROM_BANK_W > 8) ? 8 : ROM_BANK_W;
  localparam int HI_W = ROM_BANK_W - LO_W;

  logic wr_key, wr_lo, wr_hi, wr_rb;
  assign wr_key = wr && (port == RG_RAM_KEY);
  assign wr_lo  = wr && (port == RG_ROM_LO);
  assign wr_hi  = wr && (port == RG_ROM_HI);
  assign wr_rb  = wr && (port == RG_RAM_BANK);

  always_ff @(posedge clk) begin
    if (!rst_n) ram_en <= 1'b0;
    else if (wr_key) ram_en <= (wdata == RAM_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rom_bank[LO_W-1:0] <= LO_W'(1);
    else if (wr_lo) rom_bank[LO_W-1:0] <= wdata[LO_W-1:0];
  end

  generate
    if (HI_W > 0) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n) rom_bank[ROM_BANK_W-1:LO_W] <= '0;
        else if (wr_hi) rom_bank[ROM_BANK_W-1:LO_W] <= wdata[HI_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ram_bank <= '0;
    else if (wr_rb) ram_bank <= wdata[RAM_BANK_W-1:0];
  end
endmodule

// File: rtl/rom9_bank_xlate.sv
module rom9_bank_xlate
  import rom9_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13
) (
  input  window_e                          win,
  input  logic [ROM_OFS_W-1:0]             ofs,
  input  logic [ROM_BANK_W-1:0]            rom_bank,
  input  logic [RAM_BANK_W-1:0]            ram_bank,
  input  logic [ROM_BANK_W:0]              rom_cnt,
  input  logic [RAM_BANK_W:0]              ram_cnt,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0]  rom_addr,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0]  ram_addr,
  output logic                             rom_oor,
  output logic                             ram_oor
);
  logic [ROM_BANK_W-1:0] eff_bank;
  assign eff_bank = (win == WIN_FIXED) ? '0 : rom_bank;
  assign rom_addr = {eff_bank, ofs};
  assign ram_addr = {ram_bank, ofs[RAM_OFS_W-1:0]};
  assign rom_oor  = !in_range(10'(rom_bank), 10'(rom_cnt));
  assign ram_oor  = !in_range(10'(ram_bank), 10'(ram_cnt));
endmodule

// File: rtl/rom9_bank_rdmux.sv
module rom9_bank_rdmux
  import rom9_bank_pkg::*;
(
  input  window_e    win,
  input  logic       rom_oor,
  input  logic       ram_oor,
  input  logic [7:0] rom_q,
  input  logic [7:0] ram_q,
  output logic [7:0] rdata
);
  always_comb begin
    unique case (win)
      WIN_FIXED:  rdata = rom_q;
      WIN_SWITCH: rdata = rom_oor ? 8'h00 : rom_q;
      WIN_RAM:    rdata = ram_oor ? 8'h00 : ram_q;
      default:    rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rom9_bank_ctrl.sv
module rom9_bank_ctrl
  import rom9_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [15:0]                      bus_addr,
  input  logic                             bus_wr,
  input  logic [7:0]                       bus_wdata,
  output logic [7:0]                       bus_rdata,
  input  logic [ROM_BANK_W:0]              rom_banks_cfg,
  input  logic [RAM_BANK_W:0]              ram_banks_cfg,
  input  logic [7:0]                       rom_q,
  input  logic [7:0]                       ram_q,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0]  rom_addr,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0]  ram_addr,
  output logic                             ram_we,
  output logic                             rom_oor,
  output logic                             ram_oor
);
  reg_port_e             port;
  window_e               win;
  logic [ROM_BANK_W-1:0] rom_bank_q;
  logic [RAM_BANK_W-1:0] ram_bank_q;
  logic                  ram_en_q;

  assign port = decode_port(bus_addr[15:12]);
  assign win  = decode_window(bus_addr[15:12]);

  rom9_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .port(port), .wdata(bus_wdata),
    .rom_bank(rom_bank_q), .ram_bank(ram_bank_q), .ram_en(ram_en_q)
  );

  rom9_bank_xlate #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .ROM_OFS_W(ROM_OFS_W), .RAM_OFS_W(RAM_OFS_W)
  ) xlate_i (
    .win(win), .ofs(bus_addr[ROM_OFS_W-1:0]),
    .rom_bank(rom_bank_q), .ram_bank(ram_bank_q),
    .rom_cnt(rom_banks_cfg), .ram_cnt(ram_banks_cfg),
    .rom_addr(rom_addr), .ram_addr(ram_addr),
    .rom_oor(rom_oor), .ram_oor(ram_oor)
  );

  rom9_bank_rdmux rdmux_i (
    .win(win), .rom_oor(rom_oor), .ram_oor(ram_oor),
    .rom_q(rom_q), .ram_q(ram_q), .rdata(bus_rdata)
  );

  assign ram_we = bus_wr && (win == WIN_RAM) && ram_en_q && !ram_oor;
endmodule

// File: rtl/rom9_bank_ctrl_chk.sv
module rom9_bank_ctrl_chk #(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [15:0]           bus_addr,
  input logic                  bus_wr,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  ram_we,
  input logic                  rom_oor,
  input logic                  ram_oor,
  input logic [ROM_BANK_W-1:0] rom_bank,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic                  ram_en
);
  logic in_ram_win, in_sw_win, ignored_wr;
  assign in_ram_win = bus_addr[15:13] == 3'b101;
  assign in_sw_win  = bus_addr[15:14] == 2'b01;
  assign ignored_wr = !bus_wr || bus_addr[15] || (bus_addr[15:13] == 3'b011);

  AST_KEY_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b000) |=> (ram_en == ($past(bus_wdata) == 8'h0A))); // R2
  AST_LOW_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:12] == 4'h2) |=>
      (rom_bank[7:0] == $past(bus_wdata)) && $stable(rom_bank[ROM_BANK_W-1])); // R3
  AST_HIGH_BIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:12] == 4'h3) |=>
      (rom_bank[ROM_BANK_W-1] == $past(bus_wdata[0])) && $stable(rom_bank[7:0])); // R4
  AST_RAM_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[15:13] == 3'b010) |=> (ram_bank == $past(bus_wdata[RAM_BANK_W-1:0]))); // R5
  AST_ROM_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sw_win && rom_oor) |-> (bus_rdata == 8'h00)); // R10
  AST_RAM_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram_win && ram_oor) |-> (bus_rdata == 8'h00) && !ram_we); // R11
  AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (bus_wr && in_ram_win && ram_en && !ram_oor)); // R12
  AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_wr |=> $stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)); // R13
endmodule

bind rom9_bank_ctrl rom9_bank_ctrl_chk #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .ram_we(ram_we), .rom_oor(rom_oor), .ram_oor(ram_oor),
  .rom_bank(rom_bank_q), .ram_bank(ram_bank_q), .ram_en(ram_en_q)
);

// File: tb/rom9_bank_ctrl_tb_top.sv
module rom9_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [9:0]  rom_banks_cfg = 10'd512;
  logic [4:0]  ram_banks_cfg = 5'd4;
  logic [7:0]  rom_q, ram_q;
  logic [22:0] rom_addr;
  logic [16:0] ram_addr;
  logic        ram_we, rom_oor, ram_oor;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;
  logic        we_seen;

  always #4 clk = ~clk;

  // simple array models: data is a hash of the physical address
  assign rom_q = rom_addr[7:0] ^ rom_addr[21:14];
  assign ram_q = ram_addr[7:0] ^ {ram_addr[16:13], 4'hC};

  rom9_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rom_banks_cfg(rom_banks_cfg), .ram_banks_cfg(ram_banks_cfg),
    .rom_q(rom_q), .ram_q(ram_q), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .ram_we(ram_we), .rom_oor(rom_oor), .ram_oor(ram_oor)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 we_seen = ram_we;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] rom_phys(input int bank, input int ofs);
    return bank * 16384 + ofs;
  endfunction

  function automatic logic [7:0] rom_data(input int bank, input int ofs);
    return 8'(ofs) ^ 8'(bank);
  endfunction

  task automatic t_reset();
    peek(16'h4000);
    chk("R1 rom_addr after reset", 32'(rom_addr), rom_phys(1, 0));
    peek(16'hA000);
    chk("R1 ram_addr after reset", 32'(ram_addr), 32'h0);
    wr(16'hA123, 8'h77);
    chk("R1 ram_we disabled after reset", 32'(we_seen), 32'h0);
  endtask

  task automatic t_enable();
    wr(16'h0000, 8'h0A);
    wr(16'hA010, 8'h11);
    chk("R2 key 0x0A enables", 32'(we_seen), 32'h1);
    chk("R12 write in window with enable", 32'(we_seen), 32'h1);
    wr(16'h1FFF, 8'h0B);
    wr(16'hA010, 8'h11);
    chk("R2 other value disables", 32'(we_seen), 32'h0);
    wr(16'h0000, 8'h0A);
    wr(16'h9FFF, 8'h11);
    chk("R12 no we outside RAM window", 32'(we_seen), 32'h0);
  endtask

  task automatic t_low_high();
    wr(16'h3000, 8'hFF);
    wr(16'h2FFF, 8'h2A);
    peek(16'h7ABC);
    chk("R3 low byte keeps bit8", 32'(rom_addr), rom_phys(16'h12A, 16'h3ABC));
    chk("R8 switchable read data", 32'(bus_rdata), 32'(rom_data(16'h12A, 16'h3ABC)));
    wr(16'h3FFF, 8'hFE);
    peek(16'h4001);
    chk("R4 high bit keeps low byte", 32'(rom_addr), rom_phys(16'h02A, 1));
    wr(16'h2000, 8'hC3);
    wr(16'h3000, 8'h01);
    peek(16'h4000);
    chk("R8 bank 0x1C3", 32'(rom_addr), rom_phys(16'h1C3, 0));
  endtask

  task automatic t_zero_and_fixed();
    wr(16'h3000, 8'h00);
    wr(16'h2000, 8'h00);
    peek(16'h4005);
    chk("R6 bank 0 honoured", 32'(rom_addr), rom_phys(0, 5));
    chk("R6 bank 0 not out of range", 32'(rom_oor), 32'h0);
    wr(16'h2000, 8'h77);
    peek(16'h1234);
    chk("R7 fixed window address", 32'(rom_addr), 32'h1234);
    chk("R7 fixed window data", 32'(bus_rdata), 32'h34);
  endtask

  task automatic t_ram_bank();
    wr(16'h4000, 8'hF3);
    peek(16'hB456);
    chk("R5 RAM bank low nibble", 32'(ram_addr), 32'(3 * 8192 + 16'h1456));
    chk("R9 RAM read data", 32'(bus_rdata), 32'(8'h56 ^ 8'h3C));
  endtask

  task automatic t_rom_oor();
    rom_banks_cfg = 10'd64;
    wr(16'h2000, 8'h3F);
    peek(16'h5000);
    chk("R10 last bank in range", 32'(rom_oor), 32'h0);
    chk("R10 last bank data", 32'(bus_rdata), 32'(rom_data(63, 16'h1000)));
    wr(16'h2000, 8'h40);
    peek(16'h5000);
    chk("R10 bank at count flagged", 32'(rom_oor), 32'h1);
    chk("R10 read returns zero", 32'(bus_rdata), 32'h0);
    rom_banks_cfg = 10'd512;
  endtask

  task automatic t_ram_oor();
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h05);
    peek(16'hA020);
    chk("R11 bank beyond count flagged", 32'(ram_oor), 32'h1);
    chk("R11 read returns zero", 32'(bus_rdata), 32'h0);
    wr(16'hA020, 8'h99);
    chk("R11 write blocked", 32'(we_seen), 32'h0);
    wr(16'h4000, 8'h00);
    ram_banks_cfg = 5'd0;
    peek(16'hA020);
    chk("R11 no RAM fitted", 32'(ram_oor), 32'h1);
    wr(16'hA020, 8'h99);
    chk("R11 no RAM write blocked", 32'(we_seen), 32'h0);
    ram_banks_cfg = 5'd4;
  endtask

  task automatic t_ignored();
    wr(16'h2000, 8'h12);
    wr(16'h4000, 8'h02);
    wr(16'h0000, 8'h0A);
    wr(16'h6000, 8'h01);
    wr(16'h8000, 8'h55);
    wr(16'hC000, 8'h00);
    wr(16'hF000, 8'h3F);
    peek(16'h4000);
    chk("R13 ROM bank unchanged", 32'(rom_addr), rom_phys(16'h12, 0));
    peek(16'hA000);
    chk("R13 RAM bank unchanged", 32'(ram_addr), 32'(2 * 8192));
    wr(16'hA000, 8'h00);
    chk("R13 enable unchanged", 32'(we_seen), 32'h1);
  endtask

  task automatic t_timing();
    rom_banks_cfg = 10'd64;
    wr(16'h2000, 8'h3F);
    @(negedge clk);
    bus_addr = 16'h2000; bus_wdata = 8'h40; bus_wr = 1'b1;
    #1 chk("R14 old bank during write cycle", 32'(rom_oor), 32'h0);
    @(posedge clk);
    #1 bus_wr = 1'b0;
    chk("R14 new bank after edge", 32'(rom_oor), 32'h1);
    rom_banks_cfg = 10'd512;
    wr(16'h1000, 8'h00);
    wr(16'hA000, 8'h5A);
    chk("R14 disable effective next cycle", 32'(we_seen), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_enable();
    t_low_high();
    t_zero_and_fixed();
    t_ram_bank();
    t_rom_oor();
    t_ram_oor();
    t_ignored();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule